// File: doc/BRIEF.md
# Per-line MESI coherence controller

This block keeps the coherence state of a single cache line for one CPU in a small shared-memory multiprocessor. It accepts local CPU operations: load, store, atomic add, evict, and a clean that writes the line back while keeping it. It also accepts snoop messages from the interconnect: read, read-with-invalidate, invalidate and peer writeback, plus incoming read responses and invalidate acknowledgements. From these it drives outgoing request messages, snoop replies, a memory writeback strobe and a ready flag that stalls the CPU.

While a request is outstanding, the line sits in one of three waiting states. Acknowledgements are counted against a parameterised number of peer CPUs. A transition to an owning state completes only when the required response and the full acknowledgement count are both present. The line data is held in one word register so that the values supplied and written back can be observed.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line state output is 0 (Invalid), ready is 1, no message or strobe is driven and the line word is 0. State codes: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified, 4 waiting for read, 5 waiting for read-invalidate, 6 waiting for upgrade.
- R2: A load (op code 1) on an Invalid line drives request code 1 (read) and enters state 4 with ready low. On a read response the line becomes Shared, ready rises on that same edge, and the line word takes the response data.
- R3: A store (op 2) or atomic add (op 3) on an Invalid line drives request code 2 (read-invalidate) and enters state 5. It completes to Modified only once a read response and NUM_PEERS acknowledgements have arrived, in any order. The line word becomes the store data, or the response data plus the add operand.
- R4: A store or atomic add on a Shared line drives request code 3 (invalidate) and enters state 6. It becomes Modified, with the new data, on the edge that brings the NUM_PEERS-th acknowledgement.
- R5: A store or add on an Exclusive or Modified line updates the word and leaves the line Modified with no request. A load on a valid line sends nothing and changes nothing.
- R6: A snoop read (code 1) on a Modified line supplies the word as a read response, writes it back to memory, and moves the line to Shared. On an Exclusive line it supplies the word and moves to Shared. On Shared or Invalid it does nothing.
- R7: A snoop read-invalidate (code 2) on a Modified or Exclusive line drives both a read response with the word and an acknowledge, and the line goes Invalid. On Shared, Invalid or waiting lines it drives an acknowledge only; Shared goes Invalid.
- R8: A snoop invalidate (code 3) is always acknowledged. Shared, Exclusive and Modified lines go Invalid; Invalid and waiting lines keep their state.
- R9: A clean (op 5) on a Modified line writes the word back and leaves it Exclusive. An evict (op 4) on a Modified line writes it back and leaves it Invalid. An evict on Shared or Exclusive goes Invalid without a writeback.
- R10: A Shared line that receives NUM_PEERS peer-writeback snoops (code 4) becomes Exclusive.
- R11: A line in a waiting state never supplies data.
- R12: A local operation in a cycle carrying a snoop, or while ready is low, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op_i | input | 3 | Local operation code, 0 meaning none |
| cpu_wdata_i | input | DATA_W | Store data or add operand |
| cpu_ready_o | output | 1 | High when no request is outstanding |
| cpu_rdata_o | output | DATA_W | Current line word |
| line_st_o | output | 3 | Line state code |
| snp_msg_i | input | 3 | Incoming snoop message code, 0 meaning none |
| rsp_valid_i | input | 1 | Read response arriving for this line |
| rsp_data_i | input | DATA_W | Data carried by the read response |
| ack_i | input | 1 | One invalidate acknowledgement arriving |
| req_msg_o | output | 2 | Outgoing request code, 0 meaning none |
| supply_o | output | 1 | Read response sent with the line word |
| inv_ack_o | output | 1 | Invalidate acknowledgement sent |
| mem_wb_o | output | 1 | Line word written back to memory |
| data_o | output | DATA_W | Word carried by a supply or writeback |

## Verification
Every output is registered. State, ready, request, replies, writeback strobe and both data words therefore change on the clock edge that samples the causing input, and are visible one cycle after the stimulus is driven. The driver applies each stimulus on a falling edge and queues the outputs expected after the next rising edge. The monitor compares them shortly after that rising edge, so each comparison is tied to exactly one cycle. Waiting phases are stepped one acknowledgement per cycle, so that the edge carrying the last acknowledgement or response is checked on its own.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [2:0] {
    ST_I        = 3'd0,
    ST_S        = 3'd1,
    ST_E        = 3'd2,
    ST_M        = 3'd3,
    ST_WAIT_RD  = 3'd4,
    ST_WAIT_RDX = 3'd5,
    ST_WAIT_UPG = 3'd6
  } line_st_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_ADD   = 3'd3,
    OP_EVICT = 3'd4,
    OP_CLEAN = 3'd5
  } cpu_op_e;

  typedef enum logic [2:0] {
    SN_NONE     = 3'd0,
    SN_READ     = 3'd1,
    SN_READ_INV = 3'd2,
    SN_INV      = 3'd3,
    SN_PEER_WB  = 3'd4
  } snp_msg_e;

  typedef enum logic [1:0] {
    RQ_NONE     = 2'd0,
    RQ_READ     = 2'd1,
    RQ_READ_INV = 2'd2,
    RQ_INV      = 2'd3
  } req_msg_e;

  typedef enum logic [2:0] {
    DC_HOLD     = 3'd0,
    DC_LATCH    = 3'd1,
    DC_WRITE    = 3'd2,
    DC_ADD      = 3'd3,
    DC_FILL     = 3'd4,
    DC_FIN_MISS = 3'd5,
    DC_FIN_UPG  = 3'd6
  } data_cmd_e;

  function automatic logic is_wait(line_st_e s);
    return (s == ST_WAIT_RD) || (s == ST_WAIT_RDX) || (s == ST_WAIT_UPG);
  endfunction

  function automatic logic is_owner(line_st_e s);
    return (s == ST_M) || (s == ST_E);
  endfunction

endpackage

// File: rtl/mesi_ack_counter.sv
module mesi_ack_counter #(
  parameter int TARGET = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic full_o
);
  localparam int CW = $clog2(TARGET + 1);
  localparam logic [CW:0] TGT = (CW + 1)'(TARGET);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;

  assign sum    = {1'b0, cnt_q} + (CW + 1)'(inc);
  assign full_o = (sum == TGT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && ({1'b0, cnt_q} != TGT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} <= TGT)); // R3

endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
  import mesi_pkg::*;
(
  input  line_st_e  state_q_i,
  input  cpu_op_e   op_i,
  input  snp_msg_e  snp_i,
  input  logic      rsp_valid_i,
  input  logic      rsp_seen_i,
  input  logic      cnt_full_i,
  output line_st_e  state_d_o,
  output req_msg_e  req_d_o,
  output logic      supply_d_o,
  output logic      ack_d_o,
  output logic      wb_d_o,
  output data_cmd_e dcmd_o
);

  logic local_ok;

  assign local_ok = (snp_i == SN_NONE) && !is_wait(state_q_i);

  always_comb begin
    state_d_o  = state_q_i;
    req_d_o    = RQ_NONE;
    supply_d_o = 1'b0;
    ack_d_o    = 1'b0;
    wb_d_o     = 1'b0;
    dcmd_o     = DC_HOLD;

    // snoop side
    case (snp_i)
      SN_READ: begin
        if (state_q_i == ST_M) begin
          supply_d_o = 1'b1;
          wb_d_o     = 1'b1;
          state_d_o  = ST_S;
        end else if (state_q_i == ST_E) begin
          supply_d_o = 1'b1;
          state_d_o  = ST_S;
        end
      end
      SN_READ_INV: begin
        ack_d_o = 1'b1;
        if (is_owner(state_q_i)) begin
          supply_d_o = 1'b1;
        end
        if (is_owner(state_q_i) || state_q_i == ST_S) begin
          state_d_o = ST_I;
        end
      end
      SN_INV: begin
        ack_d_o = 1'b1;
        if (is_owner(state_q_i) || state_q_i == ST_S) begin
          state_d_o = ST_I;
        end
      end
      SN_PEER_WB: begin
        if (state_q_i == ST_S && cnt_full_i) begin
          state_d_o = ST_E;
        end
      end
      default: ;
    endcase

    // completion of outstanding requests
    case (state_q_i)
      ST_WAIT_RD: begin
        if (rsp_valid_i) begin
          state_d_o = ST_S;
          dcmd_o    = DC_FILL;
        end
      end
      ST_WAIT_RDX: begin
        if ((rsp_valid_i || rsp_seen_i) && cnt_full_i) begin
          state_d_o = ST_M;
          dcmd_o    = DC_FIN_MISS;
        end
      end
      ST_WAIT_UPG: begin
        if (cnt_full_i) begin
          state_d_o = ST_M;
          dcmd_o    = DC_FIN_UPG;
        end
      end
      default: ;
    endcase

    // local side
    if (local_ok) begin
      case (op_i)
        OP_LOAD: begin
          if (state_q_i == ST_I) begin
            state_d_o = ST_WAIT_RD;
            req_d_o   = RQ_READ;
          end
        end
        OP_STORE, OP_ADD: begin
          case (state_q_i)
            ST_I: begin
              state_d_o = ST_WAIT_RDX;
              req_d_o   = RQ_READ_INV;
              dcmd_o    = DC_LATCH;
            end
            ST_S: begin
              state_d_o = ST_WAIT_UPG;
              req_d_o   = RQ_INV;
              dcmd_o    = DC_LATCH;
            end
            ST_E, ST_M: begin
              state_d_o = ST_M;
              dcmd_o    = (op_i == OP_ADD) ? DC_ADD : DC_WRITE;
            end
            default: ;
          endcase
        end
        OP_EVICT: begin
          if (state_q_i == ST_M) begin
            wb_d_o = 1'b1;
          end
          if (state_q_i != ST_I) begin
            state_d_o = ST_I;
          end
        end
        OP_CLEAN: begin
          if (state_q_i == ST_M) begin
            wb_d_o    = 1'b1;
            state_d_o = ST_E;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mesi_line_data.sv
module mesi_line_data
  import mesi_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  data_cmd_e         cmd_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              supply_i,
  output logic [DATA_W-1:0] line_o,
  output logic [DATA_W-1:0] dout_o
);

  logic [DATA_W-1:0] line_q;
  logic [DATA_W-1:0] pend_w_q;
  logic              pend_add_q;
  logic [DATA_W-1:0] rsp_hold_q;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] miss_base;

  assign miss_base = rsp_valid_i ? rsp_data_i : rsp_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q     <= '0;
      pend_w_q   <= '0;
      pend_add_q <= 1'b0;
      rsp_hold_q <= '0;
      dout_q     <= '0;
    end else begin
      if (rsp_valid_i) rsp_hold_q <= rsp_data_i;
      if (supply_i)    dout_q     <= line_q;
      case (cmd_i)
        DC_LATCH: begin
          pend_w_q   <= wdata_i;
          pend_add_q <= add_i;
        end
        DC_WRITE:    line_q <= wdata_i;
        DC_ADD:      line_q <= line_q + wdata_i;
        DC_FILL:     line_q <= rsp_data_i;
        DC_FIN_MISS: line_q <= pend_add_q ? (miss_base + pend_w_q) : pend_w_q;
        DC_FIN_UPG:  line_q <= pend_add_q ? (line_q + pend_w_q) : pend_w_q;
        default: ;
      endcase
    end
  end

  assign line_o = line_q;
  assign dout_o = dout_q;

  AST_DATA_ONLY_ON_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    !$past(supply_i) |-> $stable(dout_q)); // R6

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_PEERS = 3,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cpu_op_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [2:0]        line_st_o,
  input  logic [2:0]        snp_msg_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic              ack_i,
  output logic [1:0]        req_msg_o,
  output logic              supply_o,
  output logic              inv_ack_o,
  output logic              mem_wb_o,
  output logic [DATA_W-1:0] data_o
);

  cpu_op_e   op;
  snp_msg_e  snp;
  line_st_e  state_q, state_d;
  req_msg_e  req_d, req_q;
  logic      supply_d, supply_q;
  logic      ack_d, ack_q;
  logic      wb_d, wb_q;
  logic      ready_q;
  logic      rsp_seen_q;
  logic      cnt_full;
  logic      cnt_inc;
  logic      cnt_clr;
  data_cmd_e dcmd;

  assign op  = cpu_op_e'(cpu_op_i);
  assign snp = snp_msg_e'(snp_msg_i);

  assign cnt_clr = (state_d != state_q);
  assign cnt_inc = ((state_q == ST_WAIT_RDX || state_q == ST_WAIT_UPG) && ack_i) ||
                   (state_q == ST_S && snp == SN_PEER_WB);

  mesi_ack_counter #(.TARGET(NUM_PEERS)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .full_o (cnt_full)
  );

  mesi_next_state u_ns (
    .state_q_i   (state_q),
    .op_i        (op),
    .snp_i       (snp),
    .rsp_valid_i (rsp_valid_i),
    .rsp_seen_i  (rsp_seen_q),
    .cnt_full_i  (cnt_full),
    .state_d_o   (state_d),
    .req_d_o     (req_d),
    .supply_d_o  (supply_d),
    .ack_d_o     (ack_d),
    .wb_d_o      (wb_d),
    .dcmd_o      (dcmd)
  );

  mesi_line_data #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (dcmd),
    .add_i       (op == OP_ADD),
    .wdata_i     (cpu_wdata_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .supply_i    (supply_d || wb_d),
    .line_o      (cpu_rdata_o),
    .dout_o      (data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_I;
      req_q      <= RQ_NONE;
      supply_q   <= 1'b0;
      ack_q      <= 1'b0;
      wb_q       <= 1'b0;
      ready_q    <= 1'b1;
      rsp_seen_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      req_q    <= req_d;
      supply_q <= supply_d;
      ack_q    <= ack_d;
      wb_q     <= wb_d;
      ready_q  <= !is_wait(state_d);
      if (state_d != state_q) begin
        rsp_seen_q <= 1'b0;
      end else if (state_q == ST_WAIT_RDX && rsp_valid_i) begin
        rsp_seen_q <= 1'b1;
      end
    end
  end

  assign cpu_ready_o = ready_q;
  assign line_st_o   = state_q;
  assign req_msg_o   = req_q;
  assign supply_o    = supply_q;
  assign inv_ack_o   = ack_q;
  assign mem_wb_o    = wb_q;

  AST_SUPPLY_FROM_OWNER: assert property (@(posedge clk) disable iff (rst)
    supply_o |-> $past(is_owner(state_q))); // R11

  AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req_msg_o != RQ_NONE) |-> $past(ready_q)); // R12

  AST_INV_ACKED: assert property (@(posedge clk) disable iff (rst)
    (snp == SN_INV) |=> inv_ack_o); // R8

  AST_MISS_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_WAIT_RDX && state_q == ST_M) |->
      ($past(rsp_seen_q) || $past(rsp_valid_i))); // R3

  AST_E_TO_M_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_E && state_q == ST_M) |-> (req_msg_o == RQ_NONE)); // R5

  AST_READY_LOW_WAITING: assert property (@(posedge clk) disable iff (rst)
    is_wait(state_q) |-> !cpu_ready_o); // R2

endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;

  localparam int NP = 3;
  localparam int DW = 16;

  typedef struct {
    logic [2:0]    st;
    logic          rdy;
    logic [1:0]    req;
    logic          rsp;
    logic          ack;
    logic          wb;
    logic [DW-1:0] dout;
    logic [DW-1:0] line;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cpu_op = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic [2:0]    line_st;
  logic [2:0]    snp_msg = '0;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic          ack_in = 1'b0;
  logic [1:0]    req_msg;
  logic          supply;
  logic          inv_ack;
  logic          mem_wb;
  logic [DW-1:0] data_out;

  int   n_checks = 0;
  int   n_fail   = 0;
  logic done     = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  mesi_line_ctrl #(.NUM_PEERS(NP), .DATA_W(DW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .cpu_op_i    (cpu_op),
    .cpu_wdata_i (cpu_wdata),
    .cpu_ready_o (cpu_ready),
    .cpu_rdata_o (cpu_rdata),
    .line_st_o   (line_st),
    .snp_msg_i   (snp_msg),
    .rsp_valid_i (rsp_valid),
    .rsp_data_i  (rsp_data),
    .ack_i       (ack_in),
    .req_msg_o   (req_msg),
    .supply_o    (supply),
    .inv_ack_o   (inv_ack),
    .mem_wb_o    (mem_wb),
    .data_o      (data_out)
  );

  // driver: apply one cycle of stimulus, queue what must appear after the next edge
  task automatic cyc(input logic [2:0] op, input logic [DW-1:0] wd,
                     input logic [2:0] sn, input logic rv, input logic [DW-1:0] rd,
                     input logic av,
                     input logic [2:0] e_st, input logic e_rdy, input logic [1:0] e_req,
                     input logic e_rsp, input logic e_ack, input logic e_wb,
                     input logic [DW-1:0] e_dout, input logic [DW-1:0] e_line,
                     input string tag);
    exp_t e;
    @(negedge clk);
    cpu_op = op; cpu_wdata = wd; snp_msg = sn;
    rsp_valid = rv; rsp_data = rd; ack_in = av;
    e.st = e_st; e.rdy = e_rdy; e.req = e_req; e.rsp = e_rsp; e.ack = e_ack;
    e.wb = e_wb; e.dout = e_dout; e.line = e_line; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic bad;
        e = sb_q.pop_front();
        n_checks++;
        bad = (line_st !== e.st) || (cpu_ready !== e.rdy) || (req_msg !== e.req) ||
              (supply !== e.rsp) || (inv_ack !== e.ack) || (mem_wb !== e.wb) ||
              (cpu_rdata !== e.line) ||
              ((e.rsp || e.wb) && (data_out !== e.dout));
        if (bad) begin
          n_fail++;
          $display("FAIL %s: got st=%0d rdy=%0b req=%0d rsp=%0b ack=%0b wb=%0b dout=%h line=%h; expected st=%0d rdy=%0b req=%0d rsp=%0b ack=%0b wb=%0b dout=%h line=%h",
                   e.tag, line_st, cpu_ready, req_msg, supply, inv_ack, mem_wb, data_out, cpu_rdata,
                   e.st, e.rdy, e.req, e.rsp, e.ack, e.wb, e.dout, e.line);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    //   op  wdata    sn rv rdata    av  st rdy req rsp ack wb dout     line
    cyc(0, 16'h0,    0, 0, 16'h0,    0,  0, 1, 0, 0, 0, 0, 16'h0,    16'h0,    "R1 reset");
    cyc(1, 16'h0,    0, 0, 16'h0,    0,  4, 0, 1, 0, 0, 0, 16'h0,    16'h0,    "R2 load miss issue");
    cyc(0, 16'h0,    0, 0, 16'h0,    0,  4, 0, 0, 0, 0, 0, 16'h0,    16'h0,    "R2 waiting");
    cyc(0, 16'h0,    0, 1, 16'h1234, 0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h1234, "R2 fill");
    cyc(2, 16'h0055, 0, 0, 16'h0,    0,  6, 0, 3, 0, 0, 0, 16'h0,    16'h1234, "R4 upgrade issue");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  6, 0, 0, 0, 0, 0, 16'h0,    16'h1234, "R4 ack 1");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  6, 0, 0, 0, 0, 0, 16'h0,    16'h1234, "R4 ack 2");
    cyc(0, 16'h0,    1, 0, 16'h0,    0,  6, 0, 0, 0, 0, 0, 16'h0,    16'h1234, "R11 read while waiting");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  3, 1, 0, 0, 0, 0, 16'h0,    16'h0055, "R4 last ack");
    cyc(0, 16'h0,    1, 0, 16'h0,    0,  1, 1, 0, 1, 0, 1, 16'h0055, 16'h0055, "R6 read on M");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0055, "R10 peer wb 1");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0055, "R10 peer wb 2");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  2, 1, 0, 0, 0, 0, 16'h0,    16'h0055, "R10 promote");
    cyc(2, 16'h0077, 0, 0, 16'h0,    0,  3, 1, 0, 0, 0, 0, 16'h0,    16'h0077, "R5 store on E");
    cyc(1, 16'h0,    0, 0, 16'h0,    0,  3, 1, 0, 0, 0, 0, 16'h0,    16'h0077, "R5 load hit");
    cyc(5, 16'h0,    0, 0, 16'h0,    0,  2, 1, 0, 0, 0, 1, 16'h0077, 16'h0077, "R9 clean");
    cyc(3, 16'h0001, 0, 0, 16'h0,    0,  3, 1, 0, 0, 0, 0, 16'h0,    16'h0078, "R5 add on E");
    cyc(0, 16'h0,    2, 0, 16'h0,    0,  0, 1, 0, 1, 1, 0, 16'h0078, 16'h0078, "R7 read-inv on M");
    cyc(0, 16'h0,    3, 0, 16'h0,    0,  0, 1, 0, 0, 1, 0, 16'h0,    16'h0078, "R8 inv on I");
    cyc(0, 16'h0,    1, 0, 16'h0,    0,  0, 1, 0, 0, 0, 0, 16'h0,    16'h0078, "R6 read on I");
    cyc(3, 16'h0002, 0, 0, 16'h0,    0,  5, 0, 2, 0, 0, 0, 16'h0,    16'h0078, "R3 add miss issue");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  5, 0, 0, 0, 0, 0, 16'h0,    16'h0078, "R3 ack 1");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  5, 0, 0, 0, 0, 0, 16'h0,    16'h0078, "R3 ack 2");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  5, 0, 0, 0, 0, 0, 16'h0,    16'h0078, "R3 acks full, no rsp");
    cyc(0, 16'h0,    0, 1, 16'h0100, 0,  3, 1, 0, 0, 0, 0, 16'h0,    16'h0102, "R3 rsp completes add");
    cyc(4, 16'h0,    0, 0, 16'h0,    0,  0, 1, 0, 0, 0, 1, 16'h0102, 16'h0102, "R9 evict M");
    cyc(2, 16'h0A0A, 0, 0, 16'h0,    0,  5, 0, 2, 0, 0, 0, 16'h0,    16'h0102, "R3 store miss issue");
    cyc(0, 16'h0,    0, 1, 16'h0300, 0,  5, 0, 0, 0, 0, 0, 16'h0,    16'h0102, "R3 rsp before acks");
    cyc(0, 16'h0,    3, 0, 16'h0,    0,  5, 0, 0, 0, 1, 0, 16'h0,    16'h0102, "R8 inv while waiting");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  5, 0, 0, 0, 0, 0, 16'h0,    16'h0102, "R3 ack 1");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  5, 0, 0, 0, 0, 0, 16'h0,    16'h0102, "R3 ack 2");
    cyc(0, 16'h0,    0, 0, 16'h0,    1,  3, 1, 0, 0, 0, 0, 16'h0,    16'h0A0A, "R3 last ack");
    cyc(2, 16'h1111, 1, 0, 16'h0,    0,  1, 1, 0, 1, 0, 1, 16'h0A0A, 16'h0A0A, "R12 store vs snoop");
    cyc(0, 16'h0,    3, 0, 16'h0,    0,  0, 1, 0, 0, 1, 0, 16'h0,    16'h0A0A, "R8 inv on S");
    cyc(1, 16'h0,    0, 0, 16'h0,    0,  4, 0, 1, 0, 0, 0, 16'h0,    16'h0A0A, "R2 load miss");
    cyc(2, 16'h2222, 0, 0, 16'h0,    0,  4, 0, 0, 0, 0, 0, 16'h0,    16'h0A0A, "R12 store while busy");
    cyc(0, 16'h0,    0, 1, 16'h0042, 0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0042, "R12 fill after drop");
    cyc(4, 16'h0,    0, 0, 16'h0,    0,  0, 1, 0, 0, 0, 0, 16'h0,    16'h0042, "R9 evict S");
    cyc(1, 16'h0,    0, 0, 16'h0,    0,  4, 0, 1, 0, 0, 0, 16'h0,    16'h0042, "R2 load miss");
    cyc(0, 16'h0,    0, 1, 16'h0009, 0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0009, "R2 fill");
    cyc(0, 16'h0,    2, 0, 16'h0,    0,  0, 1, 0, 0, 1, 0, 16'h0,    16'h0009, "R7 read-inv on S");
    cyc(1, 16'h0,    0, 0, 16'h0,    0,  4, 0, 1, 0, 0, 0, 16'h0,    16'h0009, "R2 load miss");
    cyc(0, 16'h0,    0, 1, 16'h0005, 0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R2 fill");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R10 peer wb 1");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R10 peer wb 2");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  2, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R10 promote");
    cyc(0, 16'h0,    1, 0, 16'h0,    0,  1, 1, 0, 1, 0, 0, 16'h0005, 16'h0005, "R6 read on E");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R10 peer wb 1");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  1, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R10 peer wb 2");
    cyc(0, 16'h0,    4, 0, 16'h0,    0,  2, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R10 promote");
    cyc(0, 16'h0,    2, 0, 16'h0,    0,  0, 1, 0, 1, 1, 0, 16'h0005, 16'h0005, "R7 read-inv on E");
    cyc(4, 16'h0,    0, 0, 16'h0,    0,  0, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R9 evict on I");
    cyc(0, 16'h0,    0, 0, 16'h0,    0,  0, 1, 0, 0, 0, 0, 16'h0,    16'h0005, "R1 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule